// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block sequences a static RAM that has a shadow nonvolatile copy of every location. In SRAM mode it decodes a chip-enable, output-enable and write-enable port. It turns that port into read and write strobes for the RAM array and drives the data bus only during a real read. In nonvolatile mode it locks the port and asks an array model, through a request/op/acknowledge handshake, to copy the whole RAM into the shadow (STORE). It can also ask the model to clear the RAM and then copy the shadow back (RECALL).

A STORE starts on any one of three triggers: loss of power-good, a falling edge on the external store request pin, or a six-read address sequence on the port. A RECALL starts when power-good rises after reset or after a power-loss STORE, or when a variant of the same address sequence is read. Any other access in the middle of the sequence sends the detector back to its first step. A busy output, meant to pull the shared store/busy line low, is active for the whole of every nonvolatile cycle. Each cycle has a clock-cycle timeout, so a missing acknowledge can never hang the block.

Top module: `nvsr_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `sb_drv`, `xfer_req`, `dq_oe`, `sram_re` and `sram_we` are all 0, and port accesses have no effect.
- R2: In SRAM mode the port is decoded from `cs_n`, `we_n` and `oe_n` as follows. With `cs_n`=1 there is no strobe and the bus is released. With `cs_n`=0 and `we_n`=0, `sram_we`=1 and the address and `dq_i` are passed through. With `cs_n`=0 and `we_n`=1, `sram_re`=1, and `dq_oe`=1 only when `oe_n`=0, with `dq_o` equal to `sram_rdata` in the same cycle.
- R3: While a nonvolatile cycle runs, `sram_re`, `sram_we` and `dq_oe` stay 0 whatever the port does, so a write attempted then leaves the RAM unchanged.
- R4: In SRAM mode, `pwr_ok` low at a clock edge starts a STORE at that edge (`xfer_op`=0).
- R5: A high-to-low change on `sb_in_n` starts a STORE at the third rising edge after the change: two synchroniser stages and one edge stage.
- R6: Six qualified reads (`cs_n`=0, `we_n`=1, with `oe_n` free) go first to the five prefix addresses in order. The sixth read goes to the store address or the recall address and starts a STORE or a RECALL at the edge that samples it. Standby cycles between the reads do not disturb the sequence.
- R7: A write, or a read of any address other than the one expected next, returns the detector to its first step. A sequence interrupted after 1 to 5 correct reads and then finished produces no cycle.
- R8: A RECALL issues op CLEAR (`xfer_op`=1) until it is acknowledged and then op COPY (`xfer_op`=2). COPY never follows anything but CLEAR, and a RECALL never issues STORE.
- R9: After a STORE that ends with `pwr_ok` low, the block idles with the port locked. When `pwr_ok` rises, a RECALL starts at the next edge.
- R10: `sb_drv` is 1 for exactly the cycles of a nonvolatile cycle. With an acknowledge arriving 5 cycles after each request phase, a STORE lasts 5 cycles and a RECALL lasts 10.
- R11: A STORE with no acknowledge ends after exactly `ST_TMO` cycles.
- R12: A RECALL with no acknowledge ends after exactly `RC_TMO` cycles in total, counted from its start.
- R13: A STORE acknowledged with `pwr_ok` high returns to SRAM mode at the next edge, and the port works again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_ok | input | 1 | Power-good, synchronous |
| cs_n | input | 1 | Port select, active low |
| we_n | input | 1 | Write select, active low |
| oe_n | input | 1 | Output drive select, active low |
| addr | input | AW | Port address |
| dq_i | input | DW | Bus data into the block |
| dq_o | output | DW | Bus data out of the block |
| dq_oe | output | 1 | Bus drive enable |
| sb_in_n | input | 1 | External store request level, active low |
| sb_drv | output | 1 | Pull the store/busy line low (busy) |
| sram_re | output | 1 | RAM array read strobe |
| sram_we | output | 1 | RAM array write strobe |
| sram_addr | output | AW | RAM array address |
| sram_wdata | output | DW | RAM array write data |
| sram_rdata | input | DW | RAM array read data |
| xfer_req | output | 1 | Array transfer request |
| xfer_op | output | 2 | Transfer op: 0 STORE, 1 CLEAR, 2 COPY |
| xfer_ack | input | 1 | One-cycle transfer done pulse |

## Verification
The assertions assume the following about the inputs. Every input is synchronous to `clk`. `sb_in_n` carries only the external pull, never the block's own `sb_drv`. `xfer_ack` pulses for one cycle, at most once per request phase, and only while `xfer_req` is high. The bench keeps to these rules by changing every input at the falling edge, by keeping the pin input and the busy output on separate wires, and by using an array model that acknowledges a fixed number of cycles after it sees a new op. For the timeout cases the model simply stays silent.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_SRAM  = 3'd1,
        S_STORE = 3'd2,
        S_RCLR  = 3'd3,
        S_RCPY  = 3'd4
    } nv_state_e;

    typedef enum logic [1:0] {
        OP_STORE = 2'd0,
        OP_CLEAR = 2'd1,
        OP_COPY  = 2'd2
    } nv_op_e;
endpackage

// File: rtl/nvsr_pin_sync.sv
module nvsr_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.sh = {q.sh[1:0], pin_n};
        fall = q.sh[2] & ~q.sh[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: 3'b111};
        else        q <= d;
    end

    // R5: one edge gives one request pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/nvsr_seq_det.sv
module nvsr_seq_det #(
    parameter int               AW   = 15,
    parameter int               NPRE = 5,
    parameter logic [NPRE*AW-1:0] PRE = '0,
    parameter logic [AW-1:0]    A_ST = '0,
    parameter logic [AW-1:0]    A_RC = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          acc_vld,
    input  logic          acc_rd,
    input  logic [AW-1:0] addr,
    output logic          hit_store,
    output logic          hit_recall
);
    localparam int SW = $clog2(NPRE + 1);

    typedef struct packed {
        logic [SW-1:0] step;
    } det_t;

    det_t q, d;
    logic [AW-1:0] want;

    always_comb begin
        want = '0;
        for (int i = 0; i < NPRE; i++)
            if (q.step == SW'(i)) want = PRE[i*AW +: AW];
    end

    always_comb begin
        d          = q;
        hit_store  = 1'b0;
        hit_recall = 1'b0;
        if (clr) begin
            d.step = '0;
        end else if (acc_vld) begin
            if (q.step == SW'(NPRE)) begin
                d.step = '0;
                if (acc_rd && addr == A_ST)      hit_store  = 1'b1;
                else if (acc_rd && addr == A_RC) hit_recall = 1'b1;
            end else if (acc_rd && addr == want) begin
                d.step = q.step + 1'b1;
            end else begin
                d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{step: '0};
        else        q <= d;
    end

    // R7: a stray access always lands on the first step
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !(acc_rd && addr == want)) |=> (q.step == '0));
    // R6: the step index never runs past the final step
    a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.step <= SW'(NPRE));
    // R6: a trigger only fires from the final step
    a_r6_hit_final: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_store || hit_recall) |-> (q.step == SW'(NPRE)));
endmodule

// File: rtl/nvsr_port_dec.sv
module nvsr_port_dec #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          en,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_i,
    input  logic [DW-1:0] sram_rdata,
    output logic          sram_re,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic          acc_vld,
    output logic          acc_rd
);
    logic sel;

    always_comb begin
        sel        = en & ~cs_n;
        sram_we    = sel & ~we_n;
        sram_re    = sel & we_n;
        dq_oe      = sel & we_n & ~oe_n;
        sram_addr  = addr;
        sram_wdata = dq_i;
        dq_o       = sram_rdata;
        acc_vld    = sel;
        acc_rd     = we_n;
    end
endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
    import nvsr_pkg::*;
#(
    parameter int                AW     = 15,
    parameter int                DW     = 8,
    parameter int                ST_TMO = 2000000,
    parameter int                RC_TMO = 4000,
    parameter logic [5*AW-1:0]   SEQ_PRE = {15'h11E3, 15'h3488, 15'h0F71, 15'h2B36, 15'h1A5C},
    parameter logic [AW-1:0]     SEQ_ST = 15'h2D0F,
    parameter logic [AW-1:0]     SEQ_RC = 15'h06B4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    input  logic          sb_in_n,
    output logic          sb_drv,
    output logic          sram_re,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    input  logic [DW-1:0] sram_rdata,
    output logic          xfer_req,
    output logic [1:0]    xfer_op,
    input  logic          xfer_ack
);
    localparam int TMAX = (ST_TMO > RC_TMO) ? ST_TMO : RC_TMO;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        nv_state_e     st;
        logic [TW-1:0] tmr;
    } ctl_t;

    ctl_t q, d;
    logic sram_mode, pin_fall, acc_vld, acc_rd, hit_store, hit_recall;

    nvsr_pin_sync u_pin (
        .clk(clk), .rst_n(rst_n), .pin_n(sb_in_n), .fall(pin_fall)
    );

    nvsr_port_dec #(.AW(AW), .DW(DW)) u_port (
        .en(sram_mode), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_i(dq_i), .sram_rdata(sram_rdata),
        .sram_re(sram_re), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .dq_o(dq_o), .dq_oe(dq_oe),
        .acc_vld(acc_vld), .acc_rd(acc_rd)
    );

    nvsr_seq_det #(.AW(AW), .NPRE(5), .PRE(SEQ_PRE), .A_ST(SEQ_ST), .A_RC(SEQ_RC)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(!sram_mode), .acc_vld(acc_vld),
        .acc_rd(acc_rd), .addr(addr), .hit_store(hit_store), .hit_recall(hit_recall)
    );

    always_comb begin
        d     = q;
        d.tmr = q.tmr + 1'b1;
        unique case (q.st)
            S_OFF: begin
                d.tmr = '0;
                if (pwr_ok) d.st = S_RCLR;
            end
            S_SRAM: begin
                d.tmr = '0;
                if (!pwr_ok || pin_fall || hit_store) d.st = S_STORE;
                else if (hit_recall)                  d.st = S_RCLR;
            end
            S_STORE: begin
                if (xfer_ack || q.tmr == TW'(ST_TMO - 1))
                    d.st = pwr_ok ? S_SRAM : S_OFF;
            end
            S_RCLR: begin
                if (q.tmr == TW'(RC_TMO - 1)) d.st = S_SRAM;
                else if (xfer_ack)            d.st = S_RCPY;
            end
            S_RCPY: begin
                if (xfer_ack || q.tmr == TW'(RC_TMO - 1)) d.st = S_SRAM;
            end
            default: d.st = S_OFF;
        endcase
    end

    always_comb begin
        sram_mode = (q.st == S_SRAM);
        xfer_req  = (q.st == S_STORE) || (q.st == S_RCLR) || (q.st == S_RCPY);
        sb_drv    = xfer_req;
        unique case (q.st)
            S_RCLR:  xfer_op = OP_CLEAR;
            S_RCPY:  xfer_op = OP_COPY;
            default: xfer_op = OP_STORE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_OFF, tmr: '0};
        else        q <= d;
    end

    // R3: no port traffic reaches the array while busy
    a_r3_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        sb_drv |-> (!sram_we && !sram_re && !dq_oe));
    // R4: power loss in SRAM mode enters STORE next
    a_r4_pwr_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SRAM && !pwr_ok) |=> (q.st == S_STORE));
    // R8: the copy phase is only reached through the clear phase
    a_r8_copy_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RCPY) |-> ($past(q.st) == S_RCLR || $past(q.st) == S_RCPY));
    // R9: powered-down idle issues nothing
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_OFF) |-> (!xfer_req && !dq_oe && !sram_re && !sram_we));
    // R11: STORE never outlives its timeout
    a_r11_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_STORE) |-> (q.tmr < TW'(ST_TMO)));
    // R12: RECALL never outlives its timeout
    a_r12_recall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RCLR || q.st == S_RCPY) |-> (q.tmr < TW'(RC_TMO)));
    // R13: acknowledged STORE with power present resumes SRAM mode
    a_r13_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_STORE && xfer_ack && pwr_ok) |=> (q.st == S_SRAM));
endmodule

// File: tb/tb_nvsr_ctrl.sv
`timescale 1ns/1ps
module tb_nvsr_ctrl;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int N  = 64;
    localparam int STT = 24;
    localparam int RCT = 16;
    localparam int LAT = 5;
    localparam logic [AW-1:0] A0 = 6'h15, A1 = 6'h2A, A2 = 6'h0B, A3 = 6'h34, A4 = 6'h1E;
    localparam logic [AW-1:0] AST = 6'h39, ARC = 6'h07;

    logic clk = 1'b0, rst_n, pwr_ok, cs_n, we_n, oe_n, sb_in_n, xfer_ack;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_i, dq_o, sram_wdata, sram_rdata;
    logic dq_oe, sb_drv, sram_re, sram_we, xfer_req;
    logic [AW-1:0] sram_addr;
    logic [1:0] xfer_op;

    logic [DW-1:0] mem [N];
    logic [DW-1:0] nv  [N];
    int n_chk = 0, n_bad = 0, order_bad = 0;
    logic [1:0] last_op = 2'd3;
    bit ack_en = 1'b1;

    always #2.5 clk = ~clk;

    nvsr_ctrl #(.AW(AW), .DW(DW), .ST_TMO(STT), .RC_TMO(RCT),
        .SEQ_PRE({A4, A3, A2, A1, A0}), .SEQ_ST(AST), .SEQ_RC(ARC)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .sb_in_n(sb_in_n), .sb_drv(sb_drv), .sram_re(sram_re), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .xfer_req(xfer_req), .xfer_op(xfer_op), .xfer_ack(xfer_ack)
    );

    assign sram_rdata = mem[sram_addr];

    initial begin
        for (int i = 0; i < N; i++) begin
            mem[i] = 8'hFF;
            nv[i]  = 8'(i) ^ 8'hA5;
        end
    end

    // array model: RAM writes and whole-array transfers
    always @(posedge clk) begin
        if (sram_we) mem[sram_addr] <= sram_wdata;
        if (xfer_ack) begin
            if (xfer_op == 2'd2 && last_op != 2'd1) order_bad <= order_bad + 1;
            last_op <= xfer_op;
            case (xfer_op)
                2'd0: for (int i = 0; i < N; i++) nv[i] <= mem[i];
                2'd1: for (int i = 0; i < N; i++) mem[i] <= '0;
                2'd2: for (int i = 0; i < N; i++) mem[i] <= nv[i];
                default: ;
            endcase
        end
    end

    // acknowledge model: LAT cycles after a new op is seen
    bit seen = 1'b0;
    logic [1:0] seen_op = 2'd0;
    int cnt = 0;
    always @(negedge clk) begin
        xfer_ack = 1'b0;
        if (xfer_req && ack_en) begin
            if (!seen || xfer_op != seen_op) begin
                seen = 1'b1; seen_op = xfer_op; cnt = 1;
            end else cnt++;
            if (cnt == LAT) xfer_ack = 1'b1;
        end else seen = 1'b0;
    end

    function automatic logic [7:0] fpat(int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic c, logic w, logic o, logic [AW-1:0] a, logic [DW-1:0] dd);
        @(negedge clk);
        cs_n = c; we_n = w; oe_n = o; addr = a; dq_i = dd;
        #1;
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic rd(logic [AW-1:0] a);
        drive(1'b0, 1'b1, 1'b0, a, '0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] dd);
        drive(1'b0, 1'b0, 1'b1, a, dd);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            idle();
            if (!sb_drv) return;
            n++;
        end
    endtask

    task automatic seq(logic [AW-1:0] last, bit gaps);
        rd(A0); if (gaps) idle();
        rd(A1); if (gaps) idle();
        rd(A2); if (gaps) idle();
        rd(A3); if (gaps) idle();
        rd(A4); if (gaps) idle();
        rd(last);
    endtask

    task automatic readback(string tag, bit use_f);
        for (int a = 0; a < N; a++) begin
            rd(AW'(a));
            chk(tag, dq_o, use_f ? fpat(a) : (8'(a) ^ 8'hA5));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; pwr_ok = 1'b0; sb_in_n = 1'b1;
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; dq_i = '0;
        idle(); idle();
        rd(6'h03);
        chk("R1 busy in reset", sb_drv, 0);
        chk("R1 req in reset", xfer_req, 0);
        chk("R1 drive in reset", dq_oe, 0);
        chk("R1 read strobe in reset", sram_re, 0);
        @(negedge clk); rst_n = 1'b1; cs_n = 1'b1; #1;
        wr(6'h03, 8'h11);
        chk("R1 write after reset", sram_we, 0);
        idle();
        rd(6'h04);
        chk("R9 read while unpowered", sram_re, 0);
        chk("R9 no busy unpowered", sb_drv, 0);

        // power-up recall
        @(negedge clk); pwr_ok = 1'b1; cs_n = 1'b1; #1;
        busy_len(n);
        chk("R10 power-up recall length", n, 10);
        chk("R8 clear before copy", order_bad, 0);
        readback("R9 recalled contents", 1'b0);

        // decode sweep
        for (int c = 0; c < 8; c++) begin
            drive(c[2], c[1], c[0], 6'h03, 8'h5A);
            chk("R2 write strobe", sram_we, !c[2] && !c[1]);
            chk("R2 read strobe", sram_re, !c[2] && c[1]);
            chk("R2 bus drive", dq_oe, !c[2] && c[1] && !c[0]);
        end

        for (int a = 0; a < N; a++) wr(AW'(a), fpat(a));
        readback("R2 write/read sweep", 1'b1);

        // interrupted sequences
        for (int k = 1; k <= 5; k++) begin
            logic [AW-1:0] steps [5];
            steps = '{A0, A1, A2, A3, A4};
            for (int j = 0; j < k; j++) rd(steps[j]);
            if (k % 2 == 0) wr(6'h00, fpat(0));
            else            rd(6'h00);
            for (int j = k; j < 5; j++) rd(steps[j]);
            rd(AST);
            idle();
            chk("R7 aborted sequence", sb_drv, 0);
        end

        // software store with standby gaps
        seq(AST, 1'b1);
        idle();
        chk("R6 store op", xfer_op, 0);
        busy_len(n);
        chk("R10 store length", n + 1, 5);
        rd(6'h01);
        chk("R13 port back after store", dq_oe, 1);

        for (int a = 0; a < N; a++) wr(AW'(a), ~fpat(a));
        seq(ARC, 1'b0);
        idle();
        chk("R8 first recall op is clear", xfer_op, 1);
        busy_len(n);
        chk("R10 recall length", n + 1, 10);
        chk("R8 order", order_bad, 0);
        readback("R6 software recall", 1'b1);

        // hardware pin store and lockout
        @(negedge clk); sb_in_n = 1'b0; cs_n = 1'b1; #1;
        idle(); chk("R5 not yet after 1 edge", sb_drv, 0);
        idle(); chk("R5 not yet after 2 edges", sb_drv, 0);
        idle(); chk("R5 busy after 3 edges", sb_drv, 1);
        sb_in_n = 1'b1;
        wr(6'h09, 8'hEE);
        chk("R3 write blocked", sram_we, 0);
        rd(6'h09);
        chk("R3 drive blocked", dq_oe, 0);
        chk("R3 read blocked", sram_re, 0);
        busy_len(n);
        rd(6'h09);
        chk("R3 location untouched", dq_o, fpat(9));

        // power fail
        @(negedge clk); pwr_ok = 1'b0; cs_n = 1'b1; #1;
        idle();
        chk("R4 store on power loss", sb_drv, 1);
        chk("R4 op", xfer_op, 0);
        busy_len(n);
        rd(6'h04);
        chk("R9 locked after power loss", dq_oe, 0);
        @(negedge clk); pwr_ok = 1'b1; cs_n = 1'b1; #1;
        busy_len(n);
        chk("R9 recall on power return", n, 10);
        rd(6'h2C);
        chk("R9 data after power cycle", dq_o, fpat(44));

        // timeouts
        ack_en = 1'b0;
        seq(AST, 1'b0);
        busy_len(n);
        chk("R11 store timeout", n, STT);
        seq(ARC, 1'b0);
        idle();
        chk("R12 stays in clear", xfer_op, 1);
        busy_len(n);
        chk("R12 recall timeout", n + 1, RCT);
        rd(6'h05);
        chk("R12 port back after timeout", dq_oe, 1);
        ack_en = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule